// File: doc/BRIEF.md
# SPI FIFO watermark interrupt controller

This block holds the transmit and receive data buffers of a serial peripheral and turns their fill levels into interrupt requests for the CPU. Each buffer is filled and drained one frame at a time. A frame-size input decides whether a frame is 8 or 16 bits wide. The block counts each buffer's fill level in bits. From that level it derives two watermark flags: transmit nearly-empty and receive nearly-full. Each threshold can be set to one of two levels.

A byte-wide control register selects the operating mode. In buffered mode each direction holds up to 64 bits. In single mode each direction holds one frame. The same register holds the two watermark thresholds, the two watermark interrupt enables and the interrupt clearing policy. Four sources can raise the interrupt line: receive data ready, transmit room available, and the two watermark flags. Under the live policy an interrupt source follows its flag. Under the latched policy a source is captured on the rising edge of its flag and stays set until software writes 1 to the matching bit of a separate clear register. The serial shift engine pushes and pops frames on the buffer ports. The CPU uses a small register bus.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset the control register reads 0x00, both fill levels are 0, both overflow bits are 0 and `irq` is 0.
- R2: The control register sits at `reg_addr`=0 and has these fields. Bit 0 turns buffered mode on. Bit 1 enables the receive nearly-full interrupt. Bit 2 enables the transmit nearly-empty interrupt. Bit 3 selects the latched clearing policy. Bit 4 is the receive threshold select. Bit 5 is the transmit threshold select. Bits 7..6 always read 0. Address 1 reads 0x00.
- R3: Each accepted frame adds 8 bits to the fill level, or 16 bits when `frame16`=1, and each pop removes that entry's own width. In buffered mode a buffer accepts frames while the total stays at or below 64 bits: 8 byte frames or 4 word frames. Frames pop out in push order.
- R4: A push that would exceed the capacity is dropped, leaves the level unchanged and sets the overflow bit of that buffer.
- R5: With buffered mode off, each buffer holds exactly one frame. A second push is dropped.
- R6: `tx_near_empty` is 1 when the transmit level is at most 16 bits while control bit 5 is 0, or at most 32 bits while bit 5 is 1.
- R7: `rx_near_full` is 1 when the receive level is at least 48 bits while control bit 4 is 0, or at least 32 bits while bit 4 is 1.
- R8: With buffered mode off, the two watermark enables have no effect: `irq` stays 0 while `rdy_ie` and `room_ie` are 0.
- R9: With control bit 3 at 0, each source is live. Receive ready means the receive level is non-zero, and `irq` falls as soon as the enabled flag clears through a level change.
- R10: With control bit 3 at 1, a source is captured on the rising edge of its flag. One cycle after that edge `irq` rises, and it stays high after the flag falls. Writing 1 to the matching bit of the clear register at `reg_addr`=1 releases it. The clear bits are: bit 0 receive ready, bit 1 transmit room, bit 2 receive nearly-full, bit 3 transmit nearly-empty.
- R11: When a clear write and a new rising edge of the same source fall in the same cycle, the source stays captured.
- R12: A control write that turns buffered mode from 1 to 0 empties both buffers and zeroes both levels and both overflow bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 control, 1 interrupt clear |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| frame16 | input | 1 | Frame size: 0 = 8 bits, 1 = 16 bits |
| rdy_ie | input | 1 | Enable for the receive-ready source |
| room_ie | input | 1 | Enable for the transmit-room source |
| tx_push | input | 1 | Write a frame into the transmit buffer |
| tx_wdata | input | 16 | Transmit frame data |
| tx_pop | input | 1 | Remove the head frame of the transmit buffer |
| tx_rdata | output | 16 | Head frame of the transmit buffer |
| rx_push | input | 1 | Write a frame into the receive buffer |
| rx_wdata | input | 16 | Receive frame data |
| rx_pop | input | 1 | Remove the head frame of the receive buffer |
| rx_rdata | output | 16 | Head frame of the receive buffer |
| tx_level | output | 7 | Transmit fill level in bits |
| rx_level | output | 7 | Receive fill level in bits |
| tx_near_empty | output | 1 | Transmit nearly-empty flag |
| rx_near_full | output | 1 | Receive nearly-full flag |
| tx_ovf | output | 1 | Transmit overflow, sticky |
| rx_ovf | output | 1 | Receive overflow, sticky |
| irq | output | 1 | Interrupt request |

## Verification
The buffers are driven with runs of byte frames and runs of word frames up to capacity and one frame past it. This separates correct per-entry bit accounting from plain entry counting, and it shows that a dropped push leaves the level untouched. Each watermark is probed on both sides of both thresholds, with the select bit toggled at a fixed level, so a swapped threshold or an off-by-one compare shows up. The interrupt path is run under the live policy, under the latched policy with the flag falling before the clear, and with a clear write landing in the same cycle as a new rising edge. These three runs separate edge capture from level following and show which side wins the collision.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

   // Interrupt sources; the value is the bit position in the clear register.
   typedef enum logic [1:0] {
      SRC_RX_READY  = 2'd0,
      SRC_TX_ROOM   = 2'd1,
      SRC_RX_NFULL  = 2'd2,
      SRC_TX_NEMPTY = 2'd3
   } src_e;

   localparam int NUM_SRC = 4;

   // Control register, packed so that bit 0 is fifo_en.
   typedef struct packed {
      logic tx_mark;
      logic rx_mark;
      logic clr_sel;
      logic tx_ie;
      logic rx_ie;
      logic fifo_en;
   } ctrl_t;

endpackage

// File: rtl/sfw_buf.sv
module sfw_buf #(
   parameter int CAP_BITS = 64,
   parameter int DATA_W   = 16,
   parameter int SMALL_W  = 8,
   localparam int LVL_W   = $clog2(CAP_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wide,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data,
   output logic [LVL_W-1:0]  level_o,
   output logic              full_o,
   output logic              ovf_o
);

   localparam int DEPTH = CAP_BITS / SMALL_W;
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("sfw_buf: CAP_BITS/SMALL_W must be a power of two >= 2");
   end
   if (DATA_W != 2 * SMALL_W || (CAP_BITS % DATA_W) != 0) begin : g_bad_width
      $error("sfw_buf: DATA_W must be 2*SMALL_W and divide CAP_BITS");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  wide_q;
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  count_q;
   logic [LVL_W-1:0]  level_q;
   logic              ovf_q;

   logic [LVL_W-1:0]  push_bits, pop_bits;
   logic              full, do_push, do_pop;

   assign push_bits = wide ? LVL_W'(DATA_W) : LVL_W'(SMALL_W);
   assign pop_bits  = wide_q[rd_ptr] ? LVL_W'(DATA_W) : LVL_W'(SMALL_W);

   always_comb begin
      if (fifo_en)
         full = ({1'b0, level_q} + {1'b0, push_bits}) > (LVL_W + 1)'(CAP_BITS);
      else
         full = (count_q != '0);
   end

   assign do_push = push_i && !full;
   assign do_pop  = pop_i && (count_q != '0);

   always_ff @(posedge clk) begin
      if (do_push && !flush_i) begin
         mem[wr_ptr]    <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         count_q <= '0;
         level_q <= '0;
         ovf_q   <= 1'b0;
         wide_q  <= '0;
      end else if (flush_i) begin
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         count_q <= '0;
         level_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (do_push) begin
            wide_q[wr_ptr] <= wide;
            wr_ptr         <= wr_ptr + PTR_W'(1);
         end
         if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
         if (push_i && full) ovf_q <= 1'b1;
         count_q <= count_q + CNT_W'(do_push) - CNT_W'(do_pop);
         level_q <= level_q + (do_push ? push_bits : '0) - (do_pop ? pop_bits : '0);
      end
   end

   assign pop_data = mem[rd_ptr];
   assign level_o  = level_q;
   assign full_o   = full;
   assign ovf_o    = ovf_q;

   AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVL_W'(CAP_BITS)); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && full && !pop_i && !flush_i |=> $stable(level_q) && ovf_q); // R4
   AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> count_q <= CNT_W'(1)); // R5
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> level_q == '0 && count_q == '0 && !ovf_q); // R12

endmodule

// File: rtl/sfw_irq_src.sv
module sfw_irq_src (
   input  logic clk,
   input  logic rst_n,
   input  logic latch_mode,
   input  logic flag_i,
   input  logic clr_i,
   output logic active_o
);

   logic flag_q, lat_q, rise;

   assign rise = flag_i && !flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         flag_q <= flag_i;
         if (latch_mode) lat_q <= (lat_q && !clr_i) || rise;
         else            lat_q <= 1'b0;
      end
   end

   assign active_o = latch_mode ? lat_q : flag_i;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      latch_mode && flag_i && !flag_q |=> lat_q); // R11
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      latch_mode && lat_q && !clr_i |=> lat_q); // R10

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
   import sfw_pkg::*;
#(
   parameter int CAP_BITS = 64,
   parameter int DATA_W   = 16,
   parameter int SMALL_W  = 8,
   localparam int LVL_W   = $clog2(CAP_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              frame16,
   input  logic              rdy_ie,
   input  logic              room_ie,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_rdata,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_wdata,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   output logic [LVL_W-1:0]  tx_level,
   output logic [LVL_W-1:0]  rx_level,
   output logic              tx_near_empty,
   output logic              rx_near_full,
   output logic              tx_ovf,
   output logic              rx_ovf,
   output logic              irq
);

   localparam int TX_MARK_LO = CAP_BITS / 4;
   localparam int TX_MARK_HI = CAP_BITS / 2;
   localparam int RX_MARK_LO = (CAP_BITS * 3) / 4;
   localparam int RX_MARK_HI = CAP_BITS / 2;

   if (CAP_BITS % 4 != 0) begin : g_bad_cap
      $error("spi_fifo_irq: CAP_BITS must be a multiple of 4");
   end

   ctrl_t ctrl_q;
   logic  ctrl_wr, flush;
   logic  unused_wdata_hi;
   logic  tx_full, unused_rx_full;
   logic [NUM_SRC-1:0] flag, act, en, clr;

   assign ctrl_wr = reg_we && (reg_addr == 1'b0);
   assign flush   = ctrl_wr && ctrl_q.fifo_en && !reg_wdata[0];
   assign unused_wdata_hi = ^reg_wdata[7:6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[5:0]);
   end

   assign reg_rdata = (reg_addr == 1'b0) ? {2'b00, ctrl_q} : 8'h00;
   assign clr = (reg_we && reg_addr) ? reg_wdata[NUM_SRC-1:0] : '0;

   sfw_buf #(.CAP_BITS(CAP_BITS), .DATA_W(DATA_W), .SMALL_W(SMALL_W)) u_txbuf (
      .clk, .rst_n,
      .fifo_en   (ctrl_q.fifo_en),
      .wide      (frame16),
      .flush_i   (flush),
      .push_i    (tx_push),
      .push_data (tx_wdata),
      .pop_i     (tx_pop),
      .pop_data  (tx_rdata),
      .level_o   (tx_level),
      .full_o    (tx_full),
      .ovf_o     (tx_ovf)
   );

   sfw_buf #(.CAP_BITS(CAP_BITS), .DATA_W(DATA_W), .SMALL_W(SMALL_W)) u_rxbuf (
      .clk, .rst_n,
      .fifo_en   (ctrl_q.fifo_en),
      .wide      (frame16),
      .flush_i   (flush),
      .push_i    (rx_push),
      .push_data (rx_wdata),
      .pop_i     (rx_pop),
      .pop_data  (rx_rdata),
      .level_o   (rx_level),
      .full_o    (unused_rx_full),
      .ovf_o     (rx_ovf)
   );

   assign tx_near_empty = tx_level <= (ctrl_q.tx_mark ? LVL_W'(TX_MARK_HI) : LVL_W'(TX_MARK_LO));
   assign rx_near_full  = rx_level >= (ctrl_q.rx_mark ? LVL_W'(RX_MARK_HI) : LVL_W'(RX_MARK_LO));

   always_comb begin
      flag[SRC_RX_READY]  = (rx_level != '0);
      flag[SRC_TX_ROOM]   = !tx_full;
      flag[SRC_RX_NFULL]  = rx_near_full;
      flag[SRC_TX_NEMPTY] = tx_near_empty;
      en[SRC_RX_READY]    = rdy_ie;
      en[SRC_TX_ROOM]     = room_ie;
      en[SRC_RX_NFULL]    = ctrl_q.rx_ie && ctrl_q.fifo_en;
      en[SRC_TX_NEMPTY]   = ctrl_q.tx_ie && ctrl_q.fifo_en;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      sfw_irq_src u_src (
         .clk, .rst_n,
         .latch_mode (ctrl_q.clr_sel),
         .flag_i     (flag[i]),
         .clr_i      (clr[i]),
         .active_o   (act[i])
      );
   end

   assign irq = |(act & en);

   AST_WM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.fifo_en && !rdy_ie && !room_ie |-> !irq); // R8

endmodule

// File: tb/spi_fifo_irq_tb.sv
module spi_fifo_irq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_addr = 1'b0, reg_we = 1'b0;
   logic [7:0]  reg_wdata = '0, reg_rdata;
   logic        frame16 = 1'b0, rdy_ie = 1'b0, room_ie = 1'b0;
   logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [15:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
   logic [6:0]  tx_level, rx_level;
   logic        tx_near_empty, rx_near_full, tx_ovf, rx_ovf, irq;

   int n_chk = 0, n_fail = 0;
   logic [15:0] tx_q[$], rx_q[$];

   always #10 clk = ~clk;

   spi_fifo_irq u_dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0; reg_addr = 1'b0;
   endtask

   // Driver: a push queues its expected frame only when it must be accepted.
   task automatic push_tx(input logic [15:0] d, input bit acc);
      tx_wdata = d; tx_push = 1'b1;
      if (acc) tx_q.push_back(d);
      tick();
      tx_push = 1'b0;
   endtask

   task automatic push_rx(input logic [15:0] d);
      rx_wdata = d; rx_push = 1'b1;
      rx_q.push_back(d);
      tick();
      rx_push = 1'b0;
   endtask

   // Monitor side: compare the head frame against the scoreboard, then pop.
   task automatic pop_tx(input string req);
      logic [15:0] e;
      e = tx_q.pop_front();
      check(req, {16'h0, tx_rdata}, {16'h0, e});
      tx_pop = 1'b1; tick(); tx_pop = 1'b0;
   endtask

   task automatic pop_rx(input string req);
      logic [15:0] e;
      e = rx_q.pop_front();
      check(req, {16'h0, rx_rdata}, {16'h0, e});
      rx_pop = 1'b1; tick(); rx_pop = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1
      check("R1 ctrl", reg_rdata, 8'h00);
      check("R1 tx_level", tx_level, 0);
      check("R1 rx_level", rx_level, 0);
      check("R1 ovf", {tx_ovf, rx_ovf}, 2'b00);
      check("R1 irq", irq, 0);
      // R2
      wr(1'b0, 8'hFF);
      check("R2 reserved bits", reg_rdata, 8'h3F);
      reg_addr = 1'b1; #1;
      check("R2 clear reg reads 0", reg_rdata, 8'h00);
      reg_addr = 1'b0;
      wr(1'b0, 8'h00);
      check("R2 ctrl cleared", reg_rdata, 8'h00);
      // R5, R8: single mode, tx watermark enable set
      wr(1'b0, 8'h04);
      check("R8 tx_near_empty live", tx_near_empty, 1);
      check("R8 irq gated", irq, 0);
      push_tx(16'h00A5, 1);
      check("R5 level one byte", tx_level, 8);
      push_tx(16'h005A, 0);
      check("R5 second push dropped", tx_level, 8);
      check("R4 overflow set", tx_ovf, 1);
      pop_tx("R5 data");
      check("R5 empty", tx_level, 0);
      // R3: buffered mode, bytes
      wr(1'b0, 8'h01);
      for (int i = 0; i < 8; i++) push_tx(16'(i * 17 + 3), 1);
      check("R3 eight bytes", tx_level, 64);
      push_tx(16'h00EE, 0);
      check("R4 ninth byte dropped", tx_level, 64);
      for (int i = 0; i < 8; i++) pop_tx("R3 byte order");
      check("R3 drained", tx_level, 0);
      // R3, R4: words
      frame16 = 1'b1;
      for (int i = 0; i < 4; i++) push_tx(16'(16'h1234 + i * 16'h1111), 1);
      check("R3 four words", tx_level, 64);
      push_tx(16'hBEEF, 0);
      check("R4 fifth word dropped", tx_level, 64);
      pop_tx("R3 word order");
      pop_tx("R3 word order");
      check("R3 two words left", tx_level, 32);
      // R6
      check("R6 32 bits mark0", tx_near_empty, 0);
      wr(1'b0, 8'h21);
      check("R6 32 bits mark1", tx_near_empty, 1);
      wr(1'b0, 8'h01);
      pop_tx("R3 word order");
      check("R6 16 bits mark0", tx_near_empty, 1);
      pop_tx("R3 word order");
      frame16 = 1'b0;
      // R7
      for (int i = 0; i < 4; i++) push_rx(16'(8'h40 + i));
      check("R7 32 bits mark0", rx_near_full, 0);
      wr(1'b0, 8'h11);
      check("R7 32 bits mark1", rx_near_full, 1);
      wr(1'b0, 8'h01);
      push_rx(16'h0055); push_rx(16'h0066);
      check("R7 48 bits mark0", rx_near_full, 1);
      pop_rx("R7 data");
      check("R7 40 bits mark0", rx_near_full, 0);
      // R9 live policy
      wr(1'b0, 8'h03);
      check("R9 below mark", irq, 0);
      push_rx(16'h0077);
      check("R9 live raise", irq, 1);
      pop_rx("R9 data");
      check("R9 live fall", irq, 0);
      // R10 latched policy
      wr(1'b0, 8'h0B);
      push_rx(16'h0088);
      check("R10 not yet captured", irq, 0);
      tick();
      check("R10 captured", irq, 1);
      pop_rx("R10 data");
      check("R10 held after flag falls", irq, 1);
      wr(1'b1, 8'h08);
      check("R10 other clear bit ignored", irq, 1);
      wr(1'b1, 8'h04);
      check("R10 released", irq, 0);
      // R11 set wins
      push_rx(16'h0099);
      wr(1'b1, 8'h04);
      check("R11 set wins", irq, 1);
      wr(1'b1, 8'h04);
      check("R11 later clear", irq, 0);
      // R12 flush
      push_tx(16'h0011, 1); push_tx(16'h0022, 1);
      check("R12 tx before", tx_level, 16);
      wr(1'b0, 8'h00);
      tx_q.delete(); rx_q.delete();
      check("R12 tx flushed", tx_level, 0);
      check("R12 rx flushed", rx_level, 0);
      check("R12 ovf cleared", {tx_ovf, rx_ovf}, 2'b00);
      // R9 receive-ready source
      rdy_ie = 1'b1; #1;
      check("R9 ready idle", irq, 0);
      push_rx(16'h00AB);
      check("R9 ready raise", irq, 1);
      pop_rx("R9 ready data");
      check("R9 ready fall", irq, 0);
      rdy_ie = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule